// File: doc/BRIEF.md
# Sign-Selectable Single-Cycle Multiply-Accumulate Unit

This block forms the product of two 16-bit operands within one clock cycle. One operand is held in a readable multiplier register and the other in a multiplicand register that cannot be read back. Before the multiply, each operand is widened to 17 bits. A separate mode bit for each operand decides the new top bit: it is zero for an unsigned operand, or a copy of bit 15 for a signed operand. A radix-4 Booth array then handles signed, unsigned and mixed products with the same hardware.

In the cycle of the multiply, the low 16 bits of the product pass straight into a 16-bit adder path. From there they are either written into a selected entry of a 32-entry accumulator bank or added to it. At the same clock edge, the high 16 bits are captured in a product-high register. A 2-bit command picks the action for the cycle. The operand-register writes and the command are plain per-cycle control pins, so the block has no stream handshake and never back-pressures. A combinational read port shows any accumulator entry.

Top module: `booth_mac`

## Requirements
- R1: After reset, the product-high register, the multiplier register and all 32 accumulators read zero.
- R2: When `mr_wr` is high, the multiplier register takes `mr_wdata` at the clock edge, and `mr_q` shows the new value from the next cycle. When `md_wr` is high, the multiplicand register is loaded the same way, but it has no read path.
- R3: Each operand is extended to 17 bits before the multiply. `mr_signed` controls the multiplier register and `md_signed` controls the multiplicand register. A mode bit of 1 copies bit 15 into bit 16; a mode bit of 0 puts a zero there.
- R4: `op` = 2'b01 (multiply only) stores product bits [31:16] in the product-high register and leaves every accumulator unchanged.
- R5: `op` = 2'b10 (multiply and load) writes product bits [15:0] into accumulator `acc_sel` and also updates the product-high register.
- R6: `op` = 2'b11 (multiply and add) adds product bits [15:0] to accumulator `acc_sel`, wrapping modulo 2^16 with no saturation, and also updates the product-high register.
- R7: `op` = 2'b00 (no operation) leaves the product-high register and all accumulators unchanged.
- R8: A multiply uses the operand register contents held before the clock edge. A register write in the same cycle only affects later multiplies.
- R9: With both operands 0xFFFF, the high and low words are: unsigned×unsigned gives 0xFFFE/0x0001, signed×signed gives 0x0000/0x0001, and either mixed case gives 0xFFFF/0x0001.
- R10: `rd_data` always shows the current contents of accumulator `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mr_wr | input | 1 | Write strobe for the multiplier register |
| mr_wdata | input | 16 | Value to load into the multiplier register |
| md_wr | input | 1 | Write strobe for the multiplicand register |
| md_wdata | input | 16 | Value to load into the multiplicand register |
| op | input | 2 | Command: 00 no-op, 01 multiply, 10 multiply+load, 11 multiply+add |
| mr_signed | input | 1 | Multiplier operand is signed |
| md_signed | input | 1 | Multiplicand operand is signed |
| acc_sel | input | 5 | Accumulator that is loaded or added to |
| rd_sel | input | 5 | Accumulator shown on the read port |
| rd_data | output | 16 | Contents of accumulator `rd_sel` |
| ph_q | output | 16 | Product-high register |
| mr_q | output | 16 | Multiplier register |

## Verification
An operand-register write and a multiply can fall in the same cycle. The bench provokes this in directed steps, where it loads a new multiplier value while a multiply is issued. It also provokes it throughout a long pseudo-random run that mixes writes and commands. The behavioural reference model applies the product from the old operands first and the register writes after, so any multiply that picks up the new value shows up as a product-high or accumulator mismatch. The same holds for a multiply-add into the entry that is being read at that moment.

// File: rtl/booth_mac_pkg.sv
`timescale 1ns/1ps
package booth_mac_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_MUL  = 2'b01,
    OP_LOAD = 2'b10,
    OP_ADD  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/booth_mul.sv
`timescale 1ns/1ps
module booth_mul #(
  parameter int EW = 17
) (
  input  logic [EW-1:0]   mcand,
  input  logic [EW-1:0]   mplier,
  output logic [2*EW-1:0] prod
);
  localparam int NG = (EW + 1) / 2;
  localparam int YW = 2 * NG;
  localparam int PW = 2 * EW;

  logic signed [YW-1:0] y_ext;
  logic [YW:0]          y_pad;
  logic signed [PW-1:0] x_ext;
  logic [PW-1:0]        pp [NG];

  assign y_ext = YW'(signed'(mplier));
  assign y_pad = {y_ext, 1'b0};
  assign x_ext = PW'(signed'(mcand));

  for (genvar g = 0; g < NG; g++) begin : g_pp
    logic [2:0]    trip;
    logic [PW-1:0] digit_val;
    assign trip = y_pad[2*g+2 : 2*g];
    always_comb begin
      case (trip)
        3'b001, 3'b010: digit_val = x_ext;
        3'b011:         digit_val = x_ext <<< 1;
        3'b100:         digit_val = -(x_ext <<< 1);
        3'b101, 3'b110: digit_val = -x_ext;
        default:        digit_val = '0;
      endcase
    end
    assign pp[g] = digit_val << (2 * g);
  end

  always_comb begin
    prod = '0;
    for (int g = 0; g < NG; g++) prod = prod + pp[g];
  end
endmodule

// File: rtl/acc_bank.sv
`timescale 1ns/1ps
module acc_bank #(
  parameter int DW   = 16,
  parameter int NACC = 32,
  localparam int AW  = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] sel_a,
  input  logic [AW-1:0] sel_b,
  output logic [DW-1:0] data_a,
  output logic [DW-1:0] data_b
);
  logic [DW-1:0] entry [NACC];

  for (genvar i = 0; i < NACC; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         entry[i] <= '0;
      else if (we && wsel == AW'(i))      entry[i] <= wdata;
    end
  end

  assign data_a = entry[sel_a];
  assign data_b = entry[sel_b];
endmodule

// File: rtl/booth_mac.sv
`timescale 1ns/1ps
module booth_mac
  import booth_mac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NACC = 32,
  localparam int AW  = $clog2(NACC),
  localparam int EW  = DW + 1,
  localparam int PW  = 2 * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_wr,
  input  logic [DW-1:0] mr_wdata,
  input  logic          md_wr,
  input  logic [DW-1:0] md_wdata,
  input  logic [1:0]    op,
  input  logic          mr_signed,
  input  logic          md_signed,
  input  logic [AW-1:0] acc_sel,
  input  logic [AW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ph_q,
  output logic [DW-1:0] mr_q
);
  mac_op_e       cmd;
  logic [DW-1:0] md_q;
  logic [EW-1:0] mr_ext, md_ext;
  logic [PW-1:0] prod;
  logic [DW-1:0] prod_lo, prod_hi;
  logic [DW-1:0] acc_cur, alu_out;
  logic          acc_we;

  assign cmd = mac_op_e'(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q <= '0;
      md_q <= '0;
    end else begin
      if (mr_wr) mr_q <= mr_wdata;
      if (md_wr) md_q <= md_wdata;
    end
  end

  assign mr_ext = {mr_signed & mr_q[DW-1], mr_q};
  assign md_ext = {md_signed & md_q[DW-1], md_q};

  booth_mul #(.EW(EW)) u_mul (
    .mcand (md_ext),
    .mplier(mr_ext),
    .prod  (prod)
  );

  assign prod_lo = prod[DW-1:0];
  assign prod_hi = prod[2*DW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (cmd != OP_NOP)  ph_q <= prod_hi;
  end

  always_comb begin
    acc_we  = 1'b0;
    alu_out = prod_lo;
    case (cmd)
      OP_LOAD: acc_we = 1'b1;
      OP_ADD: begin
        acc_we  = 1'b1;
        alu_out = acc_cur + prod_lo;
      end
      default: ;
    endcase
  end

  acc_bank #(.DW(DW), .NACC(NACC)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (acc_we),
    .wsel  (acc_sel),
    .wdata (alu_out),
    .sel_a (acc_sel),
    .sel_b (rd_sel),
    .data_a(acc_cur),
    .data_b(rd_data)
  );
endmodule

// File: rtl/booth_mac_chk.sv
`timescale 1ns/1ps
module booth_mac_chk #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int PW = 34
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mr_wr,
  input logic [DW-1:0] mr_wdata,
  input logic [1:0]    op,
  input logic          mr_signed,
  input logic          md_signed,
  input logic [AW-1:0] acc_sel,
  input logic [AW-1:0] rd_sel,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] ph_q,
  input logic [DW-1:0] mr_q,
  input logic [PW-1:0] prod
);
  // R2: a register write is visible on the next cycle
  a_r2_mr_load: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr |=> (mr_q == $past(mr_wdata)));

  // R7: no-op keeps the product-high register
  a_r7_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b00) |=> $stable(ph_q));

  // R4: any multiply captures the high word of the product
  a_r4_ph_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b00) |=> (ph_q == $past(prod[2*DW-1:DW])));

  // R5: a loaded entry, when read in the next cycle, holds the low word
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 2'b10) ##1 (rd_sel == $past(acc_sel))) |-> (rd_data == $past(prod[DW-1:0])));

  // R3: two unsigned operands never give a negative product
  a_r3_unsigned_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr_signed && !md_signed) |-> (prod[PW-1] == 1'b0));
endmodule

bind booth_mac booth_mac_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mr_wr    (mr_wr),
  .mr_wdata (mr_wdata),
  .op       (op),
  .mr_signed(mr_signed),
  .md_signed(md_signed),
  .acc_sel  (acc_sel),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .ph_q     (ph_q),
  .mr_q     (mr_q),
  .prod     (prod)
);

// File: tb/booth_mac_test.sv
`timescale 1ns/1ps
module booth_mac_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mr_wr = 1'b0, md_wr = 1'b0;
  logic [15:0] mr_wdata = '0, md_wdata = '0;
  logic [1:0]  op = 2'b00;
  logic        mr_signed = 1'b0, md_signed = 1'b0;
  logic [4:0]  acc_sel = '0, rd_sel = '0;
  logic [15:0] rd_data, ph_q, mr_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_mr, m_md, m_ph;
  logic [15:0] m_acc [32];
  int unsigned lcg = 32'h1234_5678;

  booth_mac uut (
    .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_wdata(mr_wdata),
    .md_wr(md_wr), .md_wdata(md_wdata), .op(op), .mr_signed(mr_signed),
    .md_signed(md_signed), .acc_sel(acc_sel), .rd_sel(rd_sel),
    .rd_data(rd_data), .ph_q(ph_q), .mr_q(mr_q)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic longint model_prod(logic [15:0] a, logic [15:0] b, bit as, bit bs);
    longint va, vb;
    va = as ? longint'($signed(a)) : longint'(a);
    vb = bs ? longint'($signed(b)) : longint'(b);
    return va * vb;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, return at next negedge
  task automatic step(logic [1:0] o, bit as, bit bs, logic [4:0] asel, logic [4:0] rsel,
                      bit mw, logic [15:0] mv, bit dw, logic [15:0] dv);
    longint p;
    op = o; mr_signed = as; md_signed = bs; acc_sel = asel; rd_sel = rsel;
    mr_wr = mw; mr_wdata = mv; md_wr = dw; md_wdata = dv;
    @(posedge clk);
    p = model_prod(m_mr, m_md, as, bs);   // R8: old operand values
    if (o != 2'b00) m_ph = p[31:16];
    if (o == 2'b10) m_acc[asel] = p[15:0];
    if (o == 2'b11) m_acc[asel] = m_acc[asel] + p[15:0];
    if (mw) m_mr = mv;
    if (dw) m_md = dv;
    @(negedge clk);
    mr_wr = 1'b0; md_wr = 1'b0; op = 2'b00;
  endtask

  task automatic cmp(string tag);
    chk(tag, "ph_q", ph_q, m_ph);
    chk(tag, "mr_q", mr_q, m_mr);
    chk(tag, "rd_data", rd_data, m_acc[rd_sel]);
  endtask

  task automatic scan(string tag);
    for (int i = 0; i < 32; i++) begin
      rd_sel = 5'(i);
      #1;
      chk(tag, "acc scan", rd_data, m_acc[i]);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mr = '0; m_md = '0; m_ph = '0;
    for (int i = 0; i < 32; i++) m_acc[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "ph_q", ph_q, 16'h0000);
    chk("R1", "mr_q", mr_q, 16'h0000);
    scan("R1");

    // R2: register loads
    step(2'b00, 0, 0, 0, 0, 1, 16'hFFFF, 1, 16'hFFFF);
    chk("R2", "mr_q", mr_q, 16'hFFFF);

    // R9, R3: 0xFFFF x 0xFFFF in all four mode combinations
    step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "ph uu", ph_q, 16'hFFFE);
    step(2'b10, 1, 1, 5'd3, 5'd3, 0, 0, 0, 0);
    chk("R9", "ph ss", ph_q, 16'h0000);
    chk("R9", "lo ss", rd_data, 16'h0001);
    step(2'b01, 1, 0, 0, 5'd3, 0, 0, 0, 0);
    chk("R3", "ph su", ph_q, 16'hFFFF);
    step(2'b10, 0, 1, 5'd4, 5'd4, 0, 0, 0, 0);
    chk("R3", "ph us", ph_q, 16'hFFFF);
    chk("R9", "lo us", rd_data, 16'h0001);

    // R6: wrap on add: 0xFFFF + 2 -> 0x0001
    step(2'b00, 0, 0, 0, 0, 1, 16'h0001, 0, 0);
    step(2'b10, 0, 0, 5'd5, 5'd5, 0, 0, 0, 0);
    chk("R5", "load lo", rd_data, 16'hFFFF);
    step(2'b00, 0, 0, 0, 5'd5, 0, 0, 1, 16'h0002);
    step(2'b11, 0, 0, 5'd5, 5'd5, 0, 0, 0, 0);
    chk("R6", "wrap add", rd_data, 16'h0001);
    chk("R6", "ph", ph_q, 16'h0000);

    // R4: multiply-only leaves accumulators alone
    step(2'b00, 0, 0, 0, 0, 1, 16'h7FFF, 1, 16'h7FFF);
    step(2'b01, 1, 1, 5'd5, 5'd5, 0, 0, 0, 0);
    chk("R4", "ph", ph_q, 16'h3FFF);
    chk("R4", "acc kept", rd_data, 16'h0001);

    // R7: no-op with writes keeps PH and accumulators
    step(2'b00, 1, 1, 5'd5, 5'd5, 1, 16'h1234, 1, 16'h5678);
    chk("R7", "ph kept", ph_q, 16'h3FFF);
    chk("R7", "acc kept", rd_data, 16'h0001);

    // R8: write and multiply in one cycle uses the old operand
    step(2'b01, 0, 0, 0, 0, 1, 16'hFFFF, 0, 0);
    chk("R8", "old mr used", ph_q, 16'h0626);
    step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8", "new mr used", ph_q, 16'h5677);

    // R10 and mixed: pseudo-random commands, selects, writes
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      lcg = lcg * 1664525 + 1013904223; r = lcg;
      step(r[1:0], r[2], r[3], r[8:4], (r[9] ? r[8:4] : r[14:10]),
           r[15], r[31:16], r[16], {r[23:16], r[31:24]});
      cmp("R10");
    end
    scan("R5");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule